// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block turns a free-running 16-bit up-counter into a rectangular waveform generator. Two compare values arrive as plain input ports. The period value fixes the length of one cycle, because the counter returns to zero on the count after it equals that value. The duty value fixes where the waveform changes level inside the cycle.

The waveform comes from a single output flip-flop. The flip-flop inverts each time the counter matches either compare value, so there is no plain comparator driving the pin. Software picks the starting level by presetting the flip-flop while the timer is stopped. A two-bit prescaler select divides the system clock by 1, 4, 16 or 64 to make the count clock. An output enable gates the pin, and a sticky flag records a counter wrap from all ones to zero.

A typical setup runs in this order. Stop the timer, load the period and duty values, preset the flip-flop high, set the enable, then raise the run control. The pin is then high for duty+1 count clocks and low for the rest of each period of period+1 count clocks. The valid settings are 0 ≤ duty < period ≤ FFFFh. Outside that range the block is not required to produce a correct pulse.

Top module: `ppg_timer`

## Requirements
- R1: On a count-clock tick where the counter equals `period_i`, the counter goes to 0 on the next cycle and keeps counting from there without stopping.
- R2: In steady running with valid settings, one full waveform cycle on `pulse_o` lasts (`period_i`+1)×D system clocks, where D is the prescale ratio.
- R3: With the flip-flop preset high before starting, `pulse_o` is high for (`duty_i`+1)×D clocks and low for (`period_i`−`duty_i`)×D clocks of every cycle.
- R4: The output flip-flop inverts on a tick where the counter equals `period_i`, and inverts on a tick where the counter equals `duty_i`. It holds its value on every other running cycle.
- R5: While `run_i` is 0, `lvl_cmd_i` = 01 clears the flip-flop and 10 sets it. Both codes are visible on `pulse_o` one clock later when enabled. Codes 00 and 11 leave the flip-flop unchanged.
- R6: While `run_i` is 1, `lvl_cmd_i` has no effect on the flip-flop.
- R7: `presc_sel_i` codes 0, 1, 2 and 3 give a count clock of the system clock divided by 1, 4, 16 and 64. The counter advances only on these single-cycle ticks.
- R8: `pulse_o` is a registered output. It is 0 from the cycle after `out_en_i` is sampled 0, and otherwise it follows the flip-flop.
- R9: `ovf_o` becomes 1 the cycle after a tick with the counter at FFFFh. It stays 1 until a cycle with `ovf_clr_i` = 1 clears it, and a new wrap in the same cycle wins over the clear.
- R10: Lowering `run_i` returns the counter and prescaler to zero. After `run_i` rises with divide-by-1, the first tick counts value 0, so with a high preset the first high stretch lasts `duty_i`+1 clocks including the cycle before the start.
- R11: After synchronous reset, `pulse_o` and `ovf_o` are 0 and the flip-flop is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 counts, 0 stops and clears the counter |
| period_i | input | 16 | Period compare value |
| duty_i | input | 16 | Duty compare value |
| presc_sel_i | input | 2 | Count clock select: 0 /1, 1 /4, 2 /16, 3 /64 |
| out_en_i | input | 1 | Pulse pin enable |
| lvl_cmd_i | input | 2 | Flip-flop preset: 00 keep, 01 low, 10 high, 11 ignored |
| ovf_clr_i | input | 1 | Clears the wrap flag when 1 |
| pulse_o | output | 1 | Pulse output |
| ovf_o | output | 1 | Sticky counter-wrap flag |

## Verification
The bench measures whole high and low stretches in steady state at every prescale ratio and at the edges of the valid range: duty zero, and duty one below period. A design that ended the cycle one count early or late, or that compared before rather than after the count, would show stretches one tick off. The bench checks the first stretch after a start to catch a counter that is not cleared on stop or a prescaler that is not realigned. It drives the reserved preset code and drives presets while running, and both must leave the pin unchanged. It runs a full 65536-count period to see the wrap flag rise, stay set, and clear only on request.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    LVL_KEEP = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_cmd_e;

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
  parameter int SEL_W = 2,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NCODE = 1 << SEL_W;
  localparam int PRE_W = STEP * (NCODE - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_tab [NCODE];

  // mask of low bits that must all be set for a tick, one per select code
  for (genvar g = 0; g < NCODE; g++) begin : g_mask
    assign mask_tab[g] = PRE_W'((64'(1) << (STEP * g)) - 64'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && ((pre_q & mask_tab[sel_i]) == mask_tab[sel_i]);

  // R7: a divided count clock never ticks on two cycles in a row
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel_i != '0 && run_i) |=> (!tick_o || $changed(sel_i)));

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             ovf_clr_i,
  output logic             per_hit_o,
  output logic             duty_hit_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign per_hit_o  = tick_i && (cnt_q == period_i);
  assign duty_hit_o = tick_i && (cnt_q == duty_i);
  assign wrap       = tick_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run_i)   cnt_q <= '0;
    else if (per_hit_o)  cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= wrap | (ovf_q & ~ovf_clr_i);
  end

  assign ovf_o = ovf_q;

  // R1: a period match restarts the count from zero
  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    per_hit_o |=> (cnt_q == '0));
  // R7: the counter only moves on a tick
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> $stable(cnt_q));
  // R10: stopping returns the count to zero
  p_stop_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
  // R9: wrap sets the flag, flag is sticky without a clear
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_q);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       per_hit_i,
  input  logic       duty_hit_i,
  input  logic [1:0] lvl_cmd_i,
  input  logic       out_en_i,
  output logic       pulse_o
);
  logic     ff_q, ff_d, pulse_q;
  lvl_cmd_e cmd;

  assign cmd = lvl_cmd_e'(lvl_cmd_i);

  always_comb begin
    ff_d = ff_q;
    if (!run_i) begin
      case (cmd)
        LVL_LOW:  ff_d = 1'b0;
        LVL_HIGH: ff_d = 1'b1;
        default:  ff_d = ff_q;
      endcase
    end else begin
      ff_d = ff_q ^ per_hit_i ^ duty_hit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ff_q    <= ff_d;
      pulse_q <= out_en_i & ff_d;
    end
  end

  assign pulse_o = pulse_q;

  // R6 / R4: while running the flip-flop moves only on a compare hit
  p_run_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && !per_hit_i && !duty_hit_i) |=> $stable(ff_q));
  // R4: a single hit inverts the flip-flop
  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (run_i && (per_hit_i != duty_hit_i)) |=> (ff_q != $past(ff_q)));
  // R5: presets while stopped
  p_preset_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_i && lvl_cmd_i == 2'b01) |=> !ff_q);
  p_preset_high_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_i && lvl_cmd_i == 2'b10) |=> ff_q);
  p_rsvd_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_i && lvl_cmd_i == 2'b11) |=> $stable(ff_q));

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             out_en_i,
  input  logic [1:0]       lvl_cmd_i,
  input  logic             ovf_clr_i,
  output logic             pulse_o,
  output logic             ovf_o
);
  logic tick, per_hit, duty_hit;

  ppg_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
    .clk(clk), .rst(rst), .run_i(run_i), .sel_i(presc_sel_i), .tick_o(tick)
  );

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run_i), .tick_i(tick),
    .period_i(period_i), .duty_i(duty_i), .ovf_clr_i(ovf_clr_i),
    .per_hit_o(per_hit), .duty_hit_o(duty_hit), .ovf_o(ovf_o)
  );

  ppg_outff u_ff (
    .clk(clk), .rst(rst), .run_i(run_i), .per_hit_i(per_hit),
    .duty_hit_i(duty_hit), .lvl_cmd_i(lvl_cmd_i), .out_en_i(out_en_i),
    .pulse_o(pulse_o)
  );

  // R8: disabled pin drives 0 on the following cycle
  p_pulse_off_r8: assert property (@(posedge clk) disable iff (rst)
    !out_en_i |=> !pulse_o);
  // R11: outputs are low right after reset
  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (!pulse_o && !ovf_o));

endmodule

// File: tb/sim_ppg_timer.sv
`timescale 1ns/1ps
module sim_ppg_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        run_i;
  logic [15:0] period_i, duty_i;
  logic [1:0]  presc_sel_i;
  logic        out_en_i;
  logic [1:0]  lvl_cmd_i;
  logic        ovf_clr_i;
  logic        pulse_o, ovf_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  ppg_timer u0 (
    .clk(clk), .rst(rst), .run_i(run_i), .period_i(period_i), .duty_i(duty_i),
    .presc_sel_i(presc_sel_i), .out_en_i(out_en_i), .lvl_cmd_i(lvl_cmd_i),
    .ovf_clr_i(ovf_clr_i), .pulse_o(pulse_o), .ovf_o(ovf_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input int p, input int d, input int sel);
    @(negedge clk);
    run_i = 1'b0; period_i = 16'(p); duty_i = 16'(d); presc_sel_i = 2'(sel);
    lvl_cmd_i = 2'b10; out_en_i = 1'b1;
    @(negedge clk);
    lvl_cmd_i = 2'b00;
    @(negedge clk);
  endtask

  task automatic wait_lvl(input logic v);
    for (int i = 0; i < 20000; i++) begin
      if (pulse_o == v) return;
      @(negedge clk);
    end
  endtask

  // R2 / R3 / R7: steady-state stretch lengths
  task automatic t_wave(input int p, input int d, input int sel);
    int div, h, l;
    div = 1 << (2 * sel);
    setup(p, d, sel);
    run_i = 1'b1;
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    h = 0;
    while (pulse_o && h < 20000) begin h++; @(negedge clk); end
    l = 0;
    while (!pulse_o && l < 20000) begin l++; @(negedge clk); end
    check(h == (d + 1) * div, "R3 high stretch", h, (d + 1) * div);
    check(l == (p - d) * div, "R3 low stretch", l, (p - d) * div);
    check(h + l == (p + 1) * div, "R2 R7 period", h + l, (p + 1) * div);
    check(ovf_o == 1'b0, "R9 no wrap below FFFFh", int'(ovf_o), 0);
    run_i = 1'b0;
  endtask

  task automatic t_reset;
    check(pulse_o == 1'b0, "R11 pulse after reset", int'(pulse_o), 0);
    check(ovf_o == 1'b0, "R11 ovf after reset", int'(ovf_o), 0);
  endtask

  // R5: presets and the reserved code while stopped
  task automatic t_preset;
    @(negedge clk);
    run_i = 1'b0; out_en_i = 1'b1; lvl_cmd_i = 2'b10;
    @(negedge clk);
    check(pulse_o == 1'b1, "R5 preset high", int'(pulse_o), 1);
    lvl_cmd_i = 2'b11; idle(3);
    check(pulse_o == 1'b1, "R5 code 11 keeps high", int'(pulse_o), 1);
    lvl_cmd_i = 2'b01; @(negedge clk);
    check(pulse_o == 1'b0, "R5 preset low", int'(pulse_o), 0);
    lvl_cmd_i = 2'b11; idle(3);
    check(pulse_o == 1'b0, "R5 code 11 keeps low", int'(pulse_o), 0);
    lvl_cmd_i = 2'b00; idle(3);
    check(pulse_o == 1'b0, "R5 code 00 keeps low", int'(pulse_o), 0);
  endtask

  // R6: preset while running is ignored
  task automatic t_run_cmd;
    setup(20, 9, 0);
    run_i = 1'b1;
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    lvl_cmd_i = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pulse_o == 1'b1, "R6 low preset ignored while running", int'(pulse_o), 1);
    end
    lvl_cmd_i = 2'b00;
    wait_lvl(1'b0);
    lvl_cmd_i = 2'b10;
    @(negedge clk);
    check(pulse_o == 1'b0, "R6 high preset ignored while running", int'(pulse_o), 0);
    lvl_cmd_i = 2'b00;
    run_i = 1'b0;
  endtask

  // R10 / R1: first stretch after start, then continuous restart
  task automatic t_first(input int p, input int d);
    int h, l;
    setup(p, d, 0);
    check(pulse_o == 1'b1, "R10 preset before start", int'(pulse_o), 1);
    run_i = 1'b1;
    h = 1;
    @(negedge clk);
    while (pulse_o && h < 20000) begin h++; @(negedge clk); end
    check(h == d + 1, "R10 first high stretch", h, d + 1);
    l = 0;
    while (!pulse_o && l < 20000) begin l++; @(negedge clk); end
    check(l == p - d, "R1 low stretch before restart", l, p - d);
    run_i = 1'b0;
  endtask

  // R8: enable gating
  task automatic t_enable;
    int ones;
    setup(7, 2, 0);
    run_i = 1'b1;
    idle(5);
    out_en_i = 1'b0;
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pulse_o) ones++;
    end
    check(ones == 0, "R8 disabled pin stays low", ones, 0);
    out_en_i = 1'b1;
    wait_lvl(1'b1);
    check(pulse_o == 1'b1, "R8 pin resumes when enabled", int'(pulse_o), 1);
    run_i = 1'b0;
  endtask

  // R9: wrap flag
  task automatic t_ovf;
    setup(16'hFFFF, 16'h7FFF, 0);
    run_i = 1'b1;
    idle(65000);
    check(ovf_o == 1'b0, "R9 flag before wrap", int'(ovf_o), 0);
    idle(540);
    check(ovf_o == 1'b1, "R9 flag after wrap", int'(ovf_o), 1);
    idle(200);
    check(ovf_o == 1'b1, "R9 flag sticky", int'(ovf_o), 1);
    run_i = 1'b0;
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    check(ovf_o == 1'b0, "R9 flag cleared", int'(ovf_o), 0);
  endtask

  initial begin
    rst = 1'b1; run_i = 1'b0; period_i = '0; duty_i = '0; presc_sel_i = '0;
    out_en_i = 1'b0; lvl_cmd_i = '0; ovf_clr_i = 1'b0;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preset();
    t_wave(7, 2, 0);
    t_wave(10, 0, 0);
    t_wave(12, 11, 0);
    t_wave(5, 4, 1);
    t_wave(3, 1, 2);
    t_wave(2, 0, 3);
    t_run_cmd();
    t_first(9, 3);
    t_first(4, 0);
    t_enable();
    t_ovf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule